// File: doc/BRIEF.md
# Serial Signature Analysis Register

This block compacts a serial test-response stream into a short signature for built-in self-test. Each accepted input bit is shifted into a five-stage divider whose feedback implements the fixed characteristic polynomial 1 + x^2 + x^4 + x^5. When the stream ends, the stages hold the remainder of the response polynomial divided by that characteristic polynomial. The first bit supplied is the highest-order coefficient.

A run starts with a synchronous clear. The user programs how many bits make up the response and which signature a good device leaves. When the programmed count of bits has been taken in, the block raises a one-cycle completion pulse, together with a verdict flag that compares the final remainder against the expected value. Faulty streams that alias onto the good signature go undetected. This is an accepted limit of the method.

Top module: `sig_analyzer`

## Requirements
- R1: On each accepted bit the stages update as a divider. With f = stage 4, stage 0 takes din XOR f, stage 2 takes stage 1 XOR f, stage 4 takes stage 3 XOR f, stage 1 takes stage 0 and stage 3 takes stage 2.
- R2: While rst or clr is high at a clock edge, all stages, the bit count, done and match become 0 at that edge. This takes priority over en.
- R3: A clock edge with en low changes neither the stages nor the count of accepted bits.
- R4: After a clear, the stream 1,1,1,1,0,1,0,1 with target_len 8 leaves sig = 5'b10100, which is the remainder x^4 + x^2.
- R5: done is high for exactly one cycle, following the edge that accepts the target_len-th bit since the last clear. At that point sig already shows the final signature.
- R6: match is high only while done is high, and only when the final signature equals exp_sig bit for bit (exp_sig[i] is compared with stage i).
- R7: Once target_len bits have been accepted, further enabled bits are ignored and sig holds until the next clear.
- R8: With target_len = 0, no bit is accepted and done never rises.
- R9: sig[i] presents stage i, the coefficient of x^i of the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear that starts a new run |
| en | input | 1 | Accept din on this edge |
| din | input | 1 | Serial response bit, highest-order coefficient first |
| target_len | input | CNT_W | Number of bits in a run; hold it stable during the run |
| exp_sig | input | 5 | Expected good signature; hold it stable during the run |
| sig | output | 5 | Current stage contents |
| done | output | 1 | One-cycle pulse when the run is complete |
| match | output | 1 | Final signature equals exp_sig; valid with done |

## Verification
The bench replays the worked stream and compares it against a remainder that it computes arithmetically. A wrong tap position would give a different remainder at once. It feeds bits past the programmed length to catch a register that keeps dividing, and therefore a signature that drifts after done. It inserts idle cycles inside a run to catch a divider or counter that advances without en. It also covers a length of one and a length of zero, which catch an off-by-one count that fires early, late or never. Clears and resets land mid-run with en high, to confirm they win over data. Wrong expected values are used to check that match does not follow done blindly.

// File: rtl/sig_analyzer_pkg.sv
package sig_analyzer_pkg;
  // Divider width equals the degree of the characteristic polynomial.
  localparam int SIG_W = 5;
  // Coefficients x^0..x^4 of 1 + x^2 + x^4 + x^5 (x^5 is implied by feedback).
  localparam logic [SIG_W-1:0] POLY_LOW = 5'b10101;
endpackage

// File: rtl/sig_divider.sv
module sig_divider #(
  parameter int W = sig_analyzer_pkg::SIG_W,
  parameter logic [W-1:0] TAPS = sig_analyzer_pkg::POLY_LOW
) (
  input  logic         clk,
  input  logic         zero,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = q[W-1];

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign nxt[i] = bit_in ^ (TAPS[i] & fb);
      end else begin : g_body
        assign nxt[i] = q[i-1] ^ (TAPS[i] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (zero)      q <= '0;
    else if (step) q <= nxt;
  end
endmodule

// File: rtl/sig_bit_counter.sv
module sig_bit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             zero,
  input  logic             en,
  input  logic [CNT_W-1:0] target,
  output logic             step,
  output logic             last
);
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic [CNT_W:0]   cnt_inc;

  assign full    = (cnt == target);
  assign step    = en & ~full;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign last    = step & (cnt_inc == {1'b0, target});

  always_ff @(posedge clk) begin
    if (zero)      cnt <= '0;
    else if (step) cnt <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/sig_compare.sv
module sig_compare #(
  parameter int W = sig_analyzer_pkg::SIG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  assign eq = (a == b);
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer #(
  parameter int CNT_W = 8,
  localparam int W = sig_analyzer_pkg::SIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  input  logic [CNT_W-1:0] target_len,
  input  logic [W-1:0]     exp_sig,
  output logic [W-1:0]     sig,
  output logic             done,
  output logic             match
);
  logic          zero, step, last, eq;
  logic [W-1:0]  nxt;

  assign zero = rst | clr;

  sig_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .zero(zero), .en(en), .target(target_len),
    .step(step), .last(last)
  );

  sig_divider #(.W(W), .TAPS(sig_analyzer_pkg::POLY_LOW)) u_div (
    .clk(clk), .zero(zero), .step(step), .bit_in(din),
    .nxt(nxt), .q(sig)
  );

  sig_compare #(.W(W)) u_cmp (.a(nxt), .b(exp_sig), .eq(eq));

  always_ff @(posedge clk) begin
    if (zero) begin
      done  <= 1'b0;
      match <= 1'b0;
    end else begin
      done  <= last;
      match <= last & eq;
    end
  end
endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         en,
  input logic [W-1:0] sig,
  input logic         done,
  input logic         match
);
  // R6: verdict only alongside completion
  a_r6_match_needs_done: assert property (@(posedge clk) disable iff (rst)
    match |-> done);

  // R5: completion is a single-cycle pulse
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: clear empties the register and drops the flags
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sig == '0 && !done && !match));

  // R3: idle cycles hold the stages
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(sig));

  // R5: completion only follows an enabled bit
  a_r5_done_after_en: assert property (@(posedge clk) disable iff (rst)
    (!en || clr) |=> !done);
endmodule

bind sig_analyzer sig_analyzer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .en(en),
  .sig(sig), .done(done), .match(match)
);

// File: tb/sig_analyzer_tb.sv
module sig_analyzer_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst, clr, en, din;
  logic [CNT_W-1:0] target_len;
  logic [4:0]       exp_sig;
  logic [4:0]       sig;
  logic             done, match;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model state
  int   m_rem = 0, m_cnt = 0;
  logic m_done = 0, m_match = 0;

  always #5 clk = ~clk;

  sig_analyzer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .en(en), .din(din),
    .target_len(target_len), .exp_sig(exp_sig),
    .sig(sig), .done(done), .match(match)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  // remainder arithmetic: append bit, reduce by x^5+x^4+x^2+1
  function automatic int reduce(input int r, input logic b);
    int t;
    t = (r << 1) | int'(b);
    if (t[5]) t = t ^ 'h35;
    return t & 'h1f;
  endfunction

  task automatic step(input logic c, input logic e, input logic d);
    clr = c; en = e; din = d;
    if (rst || c) begin
      m_rem = 0; m_cnt = 0; m_done = 0; m_match = 0;
    end else if (e && m_cnt != int'(target_len)) begin
      m_rem = reduce(m_rem, d);
      m_cnt++;
      m_done  = (m_cnt == int'(target_len));
      m_match = m_done && (m_rem == int'(exp_sig));
    end else begin
      m_done = 0; m_match = 0;
    end
    @(posedge clk); #2;
    // R1 R9: per-cycle comparison of stages and flags
    check("R1/R9 sig", int'(sig), m_rem);
    check("R5 done", int'(done), int'(m_done));
    check("R6 match", int'(match), int'(m_match));
  endtask

  function automatic int sig_of(input logic [31:0] bits, input int n);
    int r = 0;
    for (int i = n - 1; i >= 0; i--) r = reduce(r, bits[i]);
    return r;
  endfunction

  task automatic feed(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) step(0, 1, bits[i]);
  endtask

  initial begin
    rst = 1; clr = 0; en = 0; din = 0; target_len = 8; exp_sig = 5'h14;
    step(0, 1, 1); step(0, 1, 1);
    check("R2 reset sig", int'(sig), 0);
    check("R2 reset done", int'(done), 0);
    rst = 0;

    // R4: worked stream
    step(1, 0, 0);
    feed(32'b11110101, 8);
    check("R4 worked remainder", int'(sig), 'h14);
    check("R5 done at last bit", int'(done), 1);
    check("R6 match good", int'(match), 1);
    // R7: extra bits ignored
    step(0, 1, 1); step(0, 1, 0); step(0, 1, 1);
    check("R7 frozen sig", int'(sig), 'h14);
    check("R7 no second done", int'(done), 0);

    // R6: wrong expectation
    exp_sig = 5'h15;
    step(1, 0, 0);
    feed(32'b11110101, 8);
    check("R6 mismatch flag", int'(match), 0);
    check("R5 done on mismatch", int'(done), 1);

    // R3: idle gaps inside a run
    exp_sig = 5'h14;
    step(1, 0, 0);
    for (int i = 7; i >= 0; i--) begin
      step(0, 1, 32'b11110101 >> i);
      step(0, 0, 1); step(0, 0, 0);
    end
    check("R3 gaps same remainder", int'(sig), 'h14);

    // R2: clear with en high wins over data
    step(0, 1, 1);
    step(1, 1, 1);
    check("R2 clear over en", int'(sig), 0);

    // target of one
    target_len = 1; exp_sig = 5'h01;
    step(1, 0, 0);
    step(0, 1, 1);
    check("R5 length one done", int'(done), 1);
    check("R6 length one match", int'(match), 1);

    // R8: zero length
    target_len = 0;
    step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 1);
    check("R8 nothing accepted", int'(sig), 0);
    check("R8 done never", int'(done), 0);

    // reset mid-run
    target_len = 20;
    step(1, 0, 0);
    feed(32'h5a, 7);
    rst = 1; step(0, 1, 1); rst = 0;
    check("R2 reset mid-run", int'(sig), 0);

    // pseudo-random streams
    for (int k = 0; k < 40; k++) begin
      logic [31:0] pat;
      pat = $urandom;
      exp_sig = 5'(sig_of(pat, 20) ^ (k % 2));
      step(1, 0, 0);
      feed(pat, 20);
      check("R6 random verdict", int'(match), int'(k % 2 == 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule